// File: doc/BRIEF.md
# SD Wide-Bus Data Packet Engine

This engine moves one block of data across the data lines of an SD bus, in either narrow (DAT0 alone) or wide (DAT0 to DAT3) mode. A width select and a byte count are taken when a transfer starts. In the transmit direction the engine pulls bytes from a byte source, frames them with a start bit and an end bit, and appends a CRC16 for each line in use. It then releases the lines, reads the card's three-bit status token on DAT0, and waits for the card to stop holding DAT0 low for busy.

In the receive direction it waits for the start bit, rebuilds the bytes in nibble or bit order, and delivers each byte as a one-cycle strobe. It then checks every active line's CRC and end bit. Both directions end with a single-cycle `done` pulse. Result flags stay valid until the next transfer starts. One `clk` cycle is one bit time on the bus. The bus clock itself, command traffic and multi-block stop handling belong to other blocks.

Top module: `sdWideDataEngine`

## Requirements
- R1: After reset the engine is idle, drives no data line (`datOe` = 0), and holds `done`, `txTake` and all result flags at 0.
- R2: In narrow mode a transmitted block on DAT0 is one start bit (0), then each byte MSB first, then 16 CRC bits MSB first, then one end bit (1). Only DAT0 is driven (`datOe` = 4'b0001).
- R3: Each line's CRC is CRC16 with polynomial x^16+x^12+x^5+1 (0x1021). It starts at zero for every block, covers only the data bits of its own line, and excludes the start and end bits.
- R4: In wide mode all four lines are driven (`datOe` = 4'hF). Each byte goes out high nibble first, with nibble bit 3 on DAT3 and bit 0 on DAT0. Start bits, end bits and a separately computed CRC16 appear on every line.
- R5: The width select and byte count are latched on the start cycle. Later changes have no effect on the transfer in progress.
- R6: After the end bit the engine releases all lines. The first 0 seen on DAT0 begins the status token, and the next three DAT0 bits form it, first bit most significant. A following end bit closes it. Token 3'b010 sets `statusOk` and 3'b101 sets `statusCrcErr`. DAT1 to DAT3 are ignored throughout.
- R7: After the token's end bit, `done` pulses for one cycle in the cycle after the first DAT0 sample that is high. It never pulses while DAT0 is held low.
- R8: If DAT0 stays low for `TMO_CYC` consecutive busy samples, the engine ends with `done` and `timedOut`. It does the same if no start bit (status or receive) appears within `TMO_CYC` samples. A high DAT0 on the last allowed sample counts as a release, not a timeout.
- R9: On receive, a 0 on DAT0 is taken as the start bit. Bytes are rebuilt in the order given in R2 and R4, and each byte appears on `rxByte` with a one-cycle `rxValid` in the cycle after its last bit is sampled.
- R10: At the end of a receive block, `rxCrcErr` is set if any active line's CRC does not match or any active line's end bit is not 1. In narrow mode DAT1 to DAT3 have no effect.
- R11: `txStart` and `rxStart` are ignored while a transfer is in progress. If both are raised in the idle state, transmit wins.
- R12: `txTake` is high for exactly one cycle per byte, `blkLen` times per block. The byte on `txByte` must be valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wideMode | input | 1 | 1 selects four data lines, 0 selects DAT0 only |
| blkLen | input | LEN_W | Block length in bytes (1 to MAX_BYTES) |
| txStart | input | 1 | Start a transmit block |
| txByte | input | 8 | Next byte to send, valid while txTake is high |
| txTake | output | 1 | Byte on txByte is consumed this cycle |
| rxStart | input | 1 | Start a receive block |
| rxByte | output | 8 | Received byte |
| rxValid | output | 1 | rxByte holds a new byte |
| datIn | input | 4 | Sampled DAT3..DAT0 |
| datOut | output | 4 | Driven DAT3..DAT0 values |
| datOe | output | 4 | Per-line output enable |
| idle | output | 1 | No transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| statusOk | output | 1 | Card accepted the written block |
| statusCrcErr | output | 1 | Card reported a CRC error on the written block |
| rxCrcErr | output | 1 | Received block failed the CRC or end-bit check |
| timedOut | output | 1 | Transfer ended on the wait or busy limit |

## Verification
The busy-release test and the timeout test can fall on the same DAT0 sample: the last allowed busy cycle. The bench provokes this directly. In one block, DAT0 is held low for exactly `TMO_CYC-1` samples and then raised. In another, it is held low for `TMO_CYC` samples. The first must end with `done` and no `timedOut`. The second must end with `timedOut`, exactly `TMO_CYC` cycles after busy began.

// File: rtl/sdDpPkg.sv
package sdDpPkg;

  typedef enum logic [3:0] {
    S_IDLE, S_TSTART, S_TDATA, S_TCRC, S_TEND,
    S_SWAIT, S_STOK, S_SEND, S_BUSY,
    S_RWAIT, S_RDATA, S_RCRC, S_REND
  } engState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // take a fresh byte into the shifter
    logic shOut;     // shift transmit bits out
    logic shIn;      // shift received bits in
    logic crcClr;    // zero all lane CRCs
    logic crcUpd;    // feed one bit per lane into the CRCs
    logic crcShift;  // shift CRC out without feedback
    logic fromLine;  // CRC input comes from the lines, not the shifter
    logic emit;      // a received byte is complete
  } dpCtl_t;

  localparam logic [15:0] CRC_POLY = 16'h1021;

endpackage

// File: rtl/sdDpPath.sv
module sdDpPath
  import sdDpPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dpCtl_t     ctl,
  input  logic       wideR,
  input  logic [7:0] txByte,
  input  logic [3:0] datIn,
  output logic [3:0] txBits,
  output logic [3:0] crcMsb,
  output logic       crcClean,
  output logic [7:0] rxByte,
  output logic       rxValid
);

  localparam int LANES = 4;

  logic [7:0]       shReg;
  logic [LANES-1:0] feed;
  logic [LANES-1:0] laneNz;
  logic [LANES-1:0] laneMask;

  assign laneMask = wideR ? 4'hF : 4'h1;

  always_ff @(posedge clk) begin
    if (!rst_n)          shReg <= '0;
    else if (ctl.load)   shReg <= txByte;
    else if (ctl.shOut)  shReg <= wideR ? {shReg[3:0], 4'b0000} : {shReg[6:0], 1'b0};
    else if (ctl.shIn)   shReg <= wideR ? {shReg[3:0], datIn} : {shReg[6:0], datIn[0]};
  end

  // nibble bit 3 lands on DAT3; narrow mode uses the byte MSB on DAT0
  assign txBits = wideR ? shReg[7:4] : {3'b000, shReg[7]};
  assign feed   = ctl.fromLine ? datIn : txBits;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [15:0] crcQ;
    always_ff @(posedge clk) begin
      if (!rst_n || ctl.crcClr) crcQ <= '0;
      else if (ctl.crcUpd)      crcQ <= {crcQ[14:0], 1'b0} ^ ({16{crcQ[15] ^ feed[g]}} & CRC_POLY);
      else if (ctl.crcShift)    crcQ <= {crcQ[14:0], 1'b0};
    end
    assign crcMsb[g] = crcQ[15];
    assign laneNz[g] = |crcQ;
  end

  // message followed by its own CRC leaves a zero remainder
  assign crcClean = ~|(laneNz & laneMask);

  always_ff @(posedge clk) begin
    if (!rst_n) rxValid <= 1'b0;
    else        rxValid <= ctl.emit;
  end
  assign rxByte = shReg;

  p_crc_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl.crcClr) |-> crcClean);

  p_rx_valid_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

endmodule

// File: rtl/sdDpCtrl.sv
module sdDpCtrl
  import sdDpPkg::*;
#(
  parameter int LEN_W   = 10,
  parameter int CNT_W   = 13,
  parameter int TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wideMode,
  input  logic [LEN_W-1:0] blkLen,
  input  logic             txStart,
  input  logic             rxStart,
  input  logic [3:0]       datIn,
  input  logic [3:0]       txBits,
  input  logic [3:0]       crcMsb,
  input  logic             crcClean,
  output dpCtl_t           ctl,
  output logic             wideR,
  output logic             txTake,
  output logic [3:0]       datOut,
  output logic [3:0]       datOe,
  output logic             idle,
  output logic             done,
  output logic             statusOk,
  output logic             statusCrcErr,
  output logic             rxCrcErr,
  output logic             timedOut
);

  engState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] lenR;
  logic [2:0]       tok;
  logic [CNT_W-1:0] lastBeat;
  logic [3:0]       laneMask;
  logic             byteEdge, atLast, tmoHit, crc15;

  assign laneMask = wideR ? 4'hF : 4'h1;
  assign lastBeat = wideR ? (CNT_W'(lenR) << 1) - CNT_W'(1) : (CNT_W'(lenR) << 3) - CNT_W'(1);
  assign byteEdge = wideR ? cnt[0] : (&cnt[2:0]);
  assign atLast   = (cnt == lastBeat);
  assign tmoHit   = (cnt == CNT_W'(TMO_CYC - 1));
  assign crc15    = (cnt == CNT_W'(15));
  assign idle     = (state == S_IDLE);
  assign txTake   = ctl.load;

  always_comb begin
    ctl = '0;
    case (state)
      S_IDLE:  begin
        ctl.crcClr = txStart | rxStart;
        ctl.load   = txStart;
      end
      S_TDATA: begin
        ctl.shOut  = 1'b1;
        ctl.crcUpd = 1'b1;
        ctl.load   = byteEdge & ~atLast;
      end
      S_TCRC:  ctl.crcShift = 1'b1;
      S_RDATA: begin
        ctl.shIn     = 1'b1;
        ctl.crcUpd   = 1'b1;
        ctl.fromLine = 1'b1;
        ctl.emit     = byteEdge;
      end
      S_RCRC:  begin
        ctl.crcUpd   = 1'b1;
        ctl.fromLine = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    datOe  = '0;
    datOut = '0;
    case (state)
      S_TSTART: datOe = laneMask;
      S_TDATA:  begin datOe = laneMask; datOut = txBits & laneMask; end
      S_TCRC:   begin datOe = laneMask; datOut = crcMsb & laneMask; end
      S_TEND:   begin datOe = laneMask; datOut = laneMask; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;  cnt <= '0;  lenR <= '0;  wideR <= 1'b0;  tok <= '0;
      done <= 1'b0;  statusOk <= 1'b0;  statusCrcErr <= 1'b0;
      rxCrcErr <= 1'b0;  timedOut <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (txStart || rxStart) begin
          wideR <= wideMode;  lenR <= blkLen;  cnt <= '0;
          statusOk <= 1'b0;  statusCrcErr <= 1'b0;  rxCrcErr <= 1'b0;  timedOut <= 1'b0;
          state <= txStart ? S_TSTART : S_RWAIT;
        end
        S_TSTART: begin cnt <= '0; state <= S_TDATA; end
        S_TDATA:  if (atLast) begin cnt <= '0; state <= S_TCRC; end else cnt <= cnt + CNT_W'(1);
        S_TCRC:   if (crc15) begin cnt <= '0; state <= S_TEND; end else cnt <= cnt + CNT_W'(1);
        S_TEND:   begin cnt <= '0; state <= S_SWAIT; end
        S_SWAIT:  if (!datIn[0]) begin cnt <= '0; state <= S_STOK; end
                  else if (tmoHit) begin timedOut <= 1'b1; done <= 1'b1; state <= S_IDLE; end
                  else cnt <= cnt + CNT_W'(1);
        S_STOK:   begin
          tok <= {tok[1:0], datIn[0]};
          if (cnt == CNT_W'(2)) state <= S_SEND; else cnt <= cnt + CNT_W'(1);
        end
        S_SEND:   begin
          statusOk     <= (tok == 3'b010);
          statusCrcErr <= (tok == 3'b101);
          cnt <= '0;  state <= S_BUSY;
        end
        S_BUSY:   if (datIn[0]) begin done <= 1'b1; state <= S_IDLE; end
                  else if (tmoHit) begin timedOut <= 1'b1; done <= 1'b1; state <= S_IDLE; end
                  else cnt <= cnt + CNT_W'(1);
        S_RWAIT:  if (!datIn[0]) begin cnt <= '0; state <= S_RDATA; end
                  else if (tmoHit) begin timedOut <= 1'b1; done <= 1'b1; state <= S_IDLE; end
                  else cnt <= cnt + CNT_W'(1);
        S_RDATA:  if (atLast) begin cnt <= '0; state <= S_RCRC; end else cnt <= cnt + CNT_W'(1);
        S_RCRC:   if (crc15) begin cnt <= '0; state <= S_REND; end else cnt <= cnt + CNT_W'(1);
        S_REND:   begin
          rxCrcErr <= !crcClean || ((datIn | ~laneMask) != 4'hF);
          done <= 1'b1;  state <= S_IDLE;
        end
        default:  state <= S_IDLE;
      endcase
    end
  end

  p_done_in_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_take_then_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    txTake |=> datOe[0]);

  p_timeout_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timedOut) |-> done);

  p_busy_lines_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BUSY || state == S_STOK) |-> (datOe == 4'h0));

endmodule

// File: rtl/sdWideDataEngine.sv
module sdWideDataEngine
  import sdDpPkg::*;
#(
  parameter int MAX_BYTES = 512,
  parameter int TMO_CYC   = 4096,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int TMO_W    = $clog2(TMO_CYC + 1),
  localparam int CNT_W    = (LEN_W + 3 > TMO_W) ? LEN_W + 3 : TMO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wideMode,
  input  logic [LEN_W-1:0] blkLen,
  input  logic             txStart,
  input  logic [7:0]       txByte,
  output logic             txTake,
  input  logic             rxStart,
  output logic [7:0]       rxByte,
  output logic             rxValid,
  input  logic [3:0]       datIn,
  output logic [3:0]       datOut,
  output logic [3:0]       datOe,
  output logic             idle,
  output logic             done,
  output logic             statusOk,
  output logic             statusCrcErr,
  output logic             rxCrcErr,
  output logic             timedOut
);

  dpCtl_t     ctl;
  logic       wideR, crcClean;
  logic [3:0] txBits, crcMsb;

  sdDpCtrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .TMO_CYC(TMO_CYC)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wideMode(wideMode), .blkLen(blkLen),
    .txStart(txStart), .rxStart(rxStart), .datIn(datIn),
    .txBits(txBits), .crcMsb(crcMsb), .crcClean(crcClean),
    .ctl(ctl), .wideR(wideR), .txTake(txTake), .datOut(datOut), .datOe(datOe),
    .idle(idle), .done(done), .statusOk(statusOk), .statusCrcErr(statusCrcErr),
    .rxCrcErr(rxCrcErr), .timedOut(timedOut)
  );

  sdDpPath uPath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wideR(wideR), .txByte(txByte),
    .datIn(datIn), .txBits(txBits), .crcMsb(crcMsb), .crcClean(crcClean),
    .rxByte(rxByte), .rxValid(rxValid)
  );

endmodule

// File: tb/sdWideDataEngine_test.sv
module sdWideDataEngine_test;

  localparam int MAXB = 64;
  localparam int TMO  = 64;
  localparam int LW   = $clog2(MAXB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          wideMode = 1'b0, txStart = 1'b0, rxStart = 1'b0;
  logic [LW-1:0] blkLen = '0;
  logic [7:0]    txByte, rxByte;
  logic [3:0]    datIn = 4'hF, datOut, datOe;
  logic txTake, rxValid, idle, done, statusOk, statusCrcErr, rxCrcErr, timedOut;

  sdWideDataEngine #(.MAX_BYTES(MAXB), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .wideMode(wideMode), .blkLen(blkLen),
    .txStart(txStart), .txByte(txByte), .txTake(txTake),
    .rxStart(rxStart), .rxByte(rxByte), .rxValid(rxValid),
    .datIn(datIn), .datOut(datOut), .datOe(datOe), .idle(idle), .done(done),
    .statusOk(statusOk), .statusCrcErr(statusCrcErr), .rxCrcErr(rxCrcErr),
    .timedOut(timedOut)
  );

  int nRun = 0, nFail = 0;
  logic [7:0] txMem [MAXB];
  int takeIdx = 0, takeBase = 0;
  always @(posedge clk) if (txTake) takeIdx <= takeIdx + 1;
  assign txByte = txMem[(takeIdx - takeBase) % MAXB];

  logic [7:0] rxGot [MAXB];
  int rxCnt = 0;
  always @(negedge clk) if (rxValid) begin
    rxGot[rxCnt % MAXB] = rxByte;
    rxCnt++;
  end

  logic [3:0] frm [600];
  int frmLen;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ (((c[15] ^ b) != 1'b0) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic buildFrame(input bit wide, input int len);
    logic [15:0] c [4];
    for (int k = 0; k < 4; k++) c[k] = '0;
    frmLen = 0;
    frm[frmLen] = 4'h0; frmLen++;
    for (int i = 0; i < len; i++) begin
      if (wide) begin
        for (int h = 1; h >= 0; h--) begin
          logic [3:0] v;
          v = txMem[i][h*4 +: 4];
          frm[frmLen] = v; frmLen++;
          for (int k = 0; k < 4; k++) c[k] = crcStep(c[k], v[k]);
        end
      end else begin
        for (int b = 7; b >= 0; b--) begin
          frm[frmLen] = {3'b000, txMem[i][b]}; frmLen++;
          c[0] = crcStep(c[0], txMem[i][b]);
        end
      end
    end
    for (int j = 15; j >= 0; j--) begin
      frm[frmLen] = {c[3][j], c[2][j], c[1][j], c[0][j]}; frmLen++;
    end
    frm[frmLen] = 4'hF; frmLen++;
  endtask

  // gap < 0: no status token ever arrives
  task automatic runTx(input bit wide, input int len, input logic [2:0] tok, input int gap,
                       input int busyLen, input bit injectRx);
    logic [3:0] mask;
    logic [31:0] act, exp;
    bit bad, early, tmoExp;
    int n, rb;
    mask = wide ? 4'hF : 4'h1;
    for (int i = 0; i < len; i++) txMem[i] = 8'($urandom);
    buildFrame(wide, len);
    bad = 0; early = 0; act = 0; exp = 0;
    tmoExp = (busyLen >= TMO);
    @(negedge clk);
    takeBase = takeIdx; rb = rxCnt;
    wideMode = wide; blkLen = LW'(len); txStart = 1'b1;
    for (int j = 0; j < frmLen; j++) begin
      @(negedge clk);
      txStart  = 1'b0;
      wideMode = ~wide;                   // R5: must not disturb the block
      blkLen   = LW'(1 + ($urandom % MAXB));
      rxStart  = injectRx && (j == 3);    // R11
      if (!bad && (datOe !== mask || ((datOut ^ frm[j]) & mask) !== 4'h0)) begin
        bad = 1; act = {datOe, datOut & mask}; exp = {mask, frm[j] & mask};
      end
    end
    rxStart = 1'b0;
    check(wide ? "R4 R3 R5 wide frame" : "R2 R3 R5 narrow frame", act, exp);
    check("R12 byte takes", 32'(takeIdx - takeBase), 32'(len));
    if (injectRx) check("R11 rxStart ignored during tx", 32'(rxCnt - rb), 0);
    if (gap < 0) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!done && n < 4 * TMO);
      check("R8 status wait timeout cycles", 32'(n), 32'(TMO + 1));
      check("R8 timedOut on missing token", {31'd0, timedOut}, 1);
      return;
    end
    for (int g = 0; g < gap; g++) begin @(negedge clk); datIn = {3'($urandom), 1'b1}; end
    @(negedge clk); datIn = {3'($urandom), 1'b0};
    for (int t = 2; t >= 0; t--) begin @(negedge clk); datIn = {3'($urandom), tok[t]}; end
    @(negedge clk); datIn = {3'($urandom), 1'b1};
    for (int b = 0; b < busyLen; b++) begin
      @(negedge clk);
      if (done) early = 1;
      datIn = {3'($urandom), 1'b0};
    end
    @(negedge clk);
    check("R7 no done while busy", {31'd0, early}, 0);
    if (!tmoExp) begin
      datIn = {3'($urandom), 1'b1};
      @(negedge clk);
    end
    check("R7 done after release", {31'd0, done}, 1);
    check("R8 timeout flag", {31'd0, timedOut}, {31'd0, tmoExp});
    check("R6 status ok", {31'd0, statusOk}, {31'd0, tok == 3'b010});
    check("R6 status crc error", {31'd0, statusCrcErr}, {31'd0, tok == 3'b101});
    datIn = 4'hF;
  endtask

  // badLane < 0: intact CRC
  task automatic runRx(input bit wide, input int len, input int badLane, input bit badEnd,
                       input bit injectTx);
    bit expErr, mism, drove;
    int rb, tb;
    for (int i = 0; i < len; i++) txMem[i] = 8'($urandom);
    buildFrame(wide, len);
    if (badLane >= 0) frm[frmLen-2][badLane] = ~frm[frmLen-2][badLane];
    if (badEnd) frm[frmLen-1][0] = 1'b0;
    expErr = badEnd || (badLane >= 0 && (wide || badLane == 0));
    drove = 0; mism = 0;
    @(negedge clk);
    rb = rxCnt; tb = takeIdx;
    wideMode = wide; blkLen = LW'(len); rxStart = 1'b1; datIn = 4'hF;
    @(negedge clk); rxStart = 1'b0;
    for (int j = 0; j < frmLen; j++) begin
      @(negedge clk);
      if (datOe != 4'h0) drove = 1;
      txStart = injectTx && (j == 5);
      datIn = wide ? frm[j] : {3'($urandom), frm[j][0]};
    end
    @(negedge clk);
    txStart = 1'b0; datIn = 4'hF;
    check("R9 done after end bit", {31'd0, done}, 1);
    check("R10 crc/end check", {31'd0, rxCrcErr}, {31'd0, expErr});
    check("R9 byte count", 32'(rxCnt - rb), 32'(len));
    for (int i = 0; i < len; i++) if (rxGot[(rb + i) % MAXB] !== txMem[i]) mism = 1;
    check("R9 byte order", {31'd0, mism}, 0);
    if (injectTx) check("R11 txStart ignored during rx", {31'd0, drove} | 32'(takeIdx - tb), 0);
  endtask

  initial begin
    #(4 * 150000);
    nRun++; nFail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MAXB; i++) txMem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {31'd0, idle}, 1);
    check("R1 lines released", {28'd0, datOe}, 0);
    check("R1 flags clear", {26'd0, done, txTake, statusOk, statusCrcErr, rxCrcErr, timedOut}, 0);

    runTx(0, 1, 3'b010, 0, 3, 0);
    runTx(1, 1, 3'b101, 2, 0, 0);
    runTx(1, MAXB, 3'b010, 1, TMO - 1, 0);   // release on last allowed sample
    runTx(0, 4, 3'b010, 0, TMO, 0);          // busy limit reached
    runTx(1, 3, 3'b111, 0, 2, 1);
    runTx(0, 2, 3'b010, -1, 0, 0);
    for (int r = 0; r < 8; r++)
      runTx(1'($urandom), 1 + ($urandom % 16), ($urandom % 2) ? 3'b010 : 3'b101,
            $urandom % 4, $urandom % 10, 0);

    runRx(0, 1, -1, 0, 0);
    runRx(1, 4, -1, 0, 1);
    runRx(1, 8, 2, 0, 0);
    runRx(0, 8, 3, 0, 0);                    // inactive lane corrupted: no error
    runRx(1, 3, -1, 1, 0);
    runRx(0, MAXB, 0, 0, 0);
    for (int r = 0; r < 6; r++)
      runRx(1'($urandom), 1 + ($urandom % 16), ($urandom % 2) ? -1 : int'($urandom % 4), 0, 0);

    @(negedge clk); rxStart = 1'b1; datIn = 4'hF;
    n = 0;
    do begin @(negedge clk); rxStart = 1'b0; n++; end while (!done && n < 4 * TMO);
    check("R8 rx start timeout cycles", 32'(n), 32'(TMO + 1));
    check("R8 rx timedOut", {31'd0, timedOut}, 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule